// File: doc/BRIEF.md
# Cascadable Column-Data Capture Path

This block takes display column data from a controller, fills an 80-column row in an order chosen by a direction input, and copies the finished row into an output latch on the falling edge of a line clock. Each latched bit is then turned into a 2-bit drive-level code, using the frame alternation signal and a display-blank input. Voltage generation is not part of the block.

Data comes in on a shift strobe, either four bits per strobe (a row takes 20 strobes) or one bit per strobe (a row takes 80 strobes). Several copies can share one data bus through an enable chain. A copy takes strobes only while its chain input is low. When its last column has been filled, it pulls its chain output low and ignores any further strobes. The next copy in the chain then carries on with the row. While the line clock is high, the fill state of every copy returns to its starting point.

All inputs are sampled on `clk`. The shift strobe is a one-cycle pulse, and the line clock is a level whose falling edge is detected inside the block.

The fill sequencer is a three-state machine:
- ST_ARMED is the idle state, reached after reset or while the line clock is high.
- On the first accepted strobe it moves to ST_FILL. If that strobe is also the last one of a row, it moves straight to ST_DONE.
- It moves from ST_FILL to ST_DONE on the strobe that fills the last column.
- ST_DONE holds until the line clock is high, which returns the machine to ST_ARMED.

Top module: `lcdseg_column_path`

## Requirements
- R1: With `width_ser`=0, each accepted strobe writes four columns and a row takes 20 strobes. With `width_ser`=1, each strobe writes one column from `din[0]` only, `din[3:1]` have no effect, and a row takes 80 strobes.
- R2: Four-bit mode with `dir`=0: strobe k (k=0..19) writes columns 77-4k..80-4k. `din[0]` goes to the lowest of those columns and `din[3]` to the highest, so the first strobe fills columns 77..80.
- R3: Four-bit mode with `dir`=1: strobe k writes columns 4k+1..4k+4. `din[3]` goes to the lowest of those columns and `din[0]` to the highest, so the first strobe puts `din[0]` on column 4.
- R4: Serial mode: with `dir`=0, strobe k writes column 80-k. With `dir`=1, it writes column k+1.
- R5: A strobe that arrives while the selected chain input is high is ignored. It writes no column and does not count toward the row.
- R6: With `dir`=0, `chain_r_in` is the chain input and `chain_l_out` is the chain output. With `dir`=1, `chain_l_in` and `chain_r_out` take those roles. The unused output stays high.
- R7: The cycle after the last strobe of a row (strobe 20 or 80), the selected chain output goes low. After that, strobes are ignored until the next line-clock high.
- R8: While `line_clk` is high, the fill count clears and the chain output returns high. On the falling edge of `line_clk`, the filled row is copied into the output latch. At no other time does the latch change.
- R9: Column c drives `seg_lvl[2c-1:2c-2]`. The codes are 00=V0, 01=V2, 10=V3 and 11=V5. With `alt`=0, bit 0 gives V2 and bit 1 gives V0. With `alt`=1, bit 0 gives V3 and bit 1 gives V5. With `blank_n`=0, every column gives V0.
- R10: After reset, both chain outputs are high, and the latch and the row hold all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shift_stb | input | 1 | One-cycle data strobe |
| line_clk | input | 1 | Line clock; high rearms, falling edge latches |
| width_ser | input | 1 | 0 = four-bit transfer, 1 = serial |
| dir | input | 1 | Fill direction and chain pin selection |
| chain_l_in | input | 1 | Left chain input, active low |
| chain_r_in | input | 1 | Right chain input, active low |
| chain_l_out | output | 1 | Left chain output, active low |
| chain_r_out | output | 1 | Right chain output, active low |
| din | input | 4 | Column data |
| alt | input | 1 | Frame alternation |
| blank_n | input | 1 | Active-low display blank |
| seg_lvl | output | 160 | Drive-level code, 2 bits per column |

## Verification
The bench drives every combination of width and direction with random rows and checks the lane-to-column mapping. A design that reversed lanes within a group, or walked the groups the wrong way, would show scrambled columns. Strobes are sent while the chain input is high, and extra strobes are sent after handoff. A design that counted or wrote on those strobes would hand off early or overwrite columns. The bench checks that the chain output falls exactly after the last strobe and not one strobe earlier, that the latch holds its old row while a new row is being filled, and that the level code is right for each value of alternation and blank.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;
    typedef enum logic [1:0] {
        LV_V0 = 2'b00,
        LV_V2 = 2'b01,
        LV_V3 = 2'b10,
        LV_V5 = 2'b11
    } lvl_t;

    typedef enum logic [1:0] {
        ST_ARMED = 2'b00,
        ST_FILL  = 2'b01,
        ST_DONE  = 2'b10
    } fill_st_t;
endpackage

// File: rtl/seg_fill_ctrl.sv
module seg_fill_ctrl
    import lcdseg_pkg::*;
#(
    parameter int NCOL = 80,
    parameter int NPAR = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_stb,
    input  logic                    line_clk,
    input  logic                    width_ser,
    input  logic                    dir,
    input  logic                    chain_l_in,
    input  logic                    chain_r_in,
    output logic                    chain_l_out,
    output logic                    chain_r_out,
    output logic                    wr_en,
    output logic [$clog2(NCOL)-1:0] wr_idx
);
    localparam int CLK_PAR = NCOL / NPAR;
    localparam int CNT_W   = $clog2(NCOL);
    localparam logic [CNT_W-1:0] LAST_PAR = CNT_W'(CLK_PAR - 1);
    localparam logic [CNT_W-1:0] LAST_SER = CNT_W'(NCOL - 1);

    fill_st_t         st_q, st_nxt;
    logic [CNT_W-1:0] cnt_q;
    logic             pass_q;
    logic             en_in;
    logic             acc;
    logic             at_last;
    logic [CNT_W-1:0] last_idx;

    assign en_in    = dir ? chain_l_in : chain_r_in;
    assign last_idx = width_ser ? LAST_SER : LAST_PAR;
    assign at_last  = (cnt_q == last_idx);
    assign acc      = shift_stb && !en_in && !line_clk && (st_q != ST_DONE);

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_ARMED: if (acc) st_nxt = at_last ? ST_DONE : ST_FILL;
            ST_FILL:  if (acc && at_last) st_nxt = ST_DONE;
            ST_DONE:  st_nxt = ST_DONE;
            default:  st_nxt = ST_ARMED;
        endcase
        if (line_clk) st_nxt = ST_ARMED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_ARMED;
        else        st_q <= st_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pass_q <= 1'b0;
        end else if (line_clk) begin
            cnt_q  <= '0;
            pass_q <= 1'b0;
        end else if (acc) begin
            if (at_last) pass_q <= 1'b1;
            else         cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign chain_l_out = dir ? 1'b1 : ~pass_q;
    assign chain_r_out = dir ? ~pass_q : 1'b1;
    assign wr_en       = acc;
    assign wr_idx      = cnt_q;

    AST_IGNORE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_stb && en_in && !line_clk) |=> $stable(cnt_q)); // R5
    AST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && at_last) |=> ($past(dir) ? !chain_r_out : !chain_l_out)); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(NCOL)); // R1
    AST_LINE_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        line_clk |=> (cnt_q == '0 && st_q == ST_ARMED && chain_l_out && chain_r_out)); // R8
    AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE && !line_clk) |=> $stable(cnt_q)); // R7
    AST_IDLE_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (dir ? chain_l_out : chain_r_out)); // R6
endmodule

// File: rtl/seg_row_store.sv
module seg_row_store #(
    parameter int NCOL = 80,
    parameter int NPAR = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [$clog2(NCOL)-1:0] wr_idx,
    input  logic                    width_ser,
    input  logic                    dir,
    input  logic [NPAR-1:0]         din,
    input  logic                    line_clk,
    output logic [NCOL-1:0]         lat_bits
);
    localparam int CLK_PAR = NCOL / NPAR;
    localparam int CNT_W   = $clog2(NCOL);

    logic [NCOL-1:0] row_q;
    logic [NCOL-1:0] lat_q;
    logic            line_d;
    logic            line_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_d <= 1'b0;
        else        line_d <= line_clk;
    end
    assign line_fall = line_d && !line_clk;

    for (genvar j = 0; j < NCOL; j++) begin : g_col
        localparam int GRP = j / NPAR;
        localparam int LN  = j % NPAR;
        localparam logic [CNT_W-1:0] K_PAR_LO = CNT_W'(CLK_PAR - 1 - GRP);
        localparam logic [CNT_W-1:0] K_PAR_HI = CNT_W'(GRP);
        localparam logic [CNT_W-1:0] K_SER_LO = CNT_W'(NCOL - 1 - j);
        localparam logic [CNT_W-1:0] K_SER_HI = CNT_W'(j);
        logic hit;
        logic bit_in;

        always_comb begin
            if (width_ser) begin
                hit    = dir ? (wr_idx == K_SER_HI) : (wr_idx == K_SER_LO);
                bit_in = din[0];
            end else begin
                hit    = dir ? (wr_idx == K_PAR_HI) : (wr_idx == K_PAR_LO);
                bit_in = dir ? din[NPAR-1-LN] : din[LN];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             row_q[j] <= 1'b0;
            else if (wr_en && hit)  row_q[j] <= bit_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         lat_q <= '0;
        else if (line_fall) lat_q <= row_q;
    end

    assign lat_bits = lat_q;

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_d && !line_clk) |=> $stable(lat_q)); // R8
    AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (line_d && !line_clk) |=> (lat_q == $past(row_q))); // R8
endmodule

// File: rtl/seg_level_map.sv
module seg_level_map
    import lcdseg_pkg::*;
#(
    parameter int NCOL = 80
) (
    input  logic [NCOL-1:0]   lat_bits,
    input  logic              alt,
    input  logic              blank_n,
    output logic [2*NCOL-1:0] seg_lvl
);
    for (genvar c = 0; c < NCOL; c++) begin : g_lvl
        lvl_t code;
        always_comb begin
            if (!blank_n)     code = LV_V0;
            else if (!alt)    code = lat_bits[c] ? LV_V0 : LV_V2;
            else              code = lat_bits[c] ? LV_V5 : LV_V3;
        end
        assign seg_lvl[2*c +: 2] = code;
    end
endmodule

// File: rtl/lcdseg_column_path.sv
module lcdseg_column_path #(
    parameter int NCOL = 80,
    parameter int NPAR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_stb,
    input  logic              line_clk,
    input  logic              width_ser,
    input  logic              dir,
    input  logic              chain_l_in,
    input  logic              chain_r_in,
    output logic              chain_l_out,
    output logic              chain_r_out,
    input  logic [NPAR-1:0]   din,
    input  logic              alt,
    input  logic              blank_n,
    output logic [2*NCOL-1:0] seg_lvl
);
    localparam int CNT_W = $clog2(NCOL);

    logic             wr_en;
    logic [CNT_W-1:0] wr_idx;
    logic [NCOL-1:0]  lat_bits;

    seg_fill_ctrl #(.NCOL(NCOL), .NPAR(NPAR)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .shift_stb(shift_stb), .line_clk(line_clk),
        .width_ser(width_ser), .dir(dir), .chain_l_in(chain_l_in),
        .chain_r_in(chain_r_in), .chain_l_out(chain_l_out),
        .chain_r_out(chain_r_out), .wr_en(wr_en), .wr_idx(wr_idx)
    );

    seg_row_store #(.NCOL(NCOL), .NPAR(NPAR)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .width_ser(width_ser), .dir(dir), .din(din), .line_clk(line_clk),
        .lat_bits(lat_bits)
    );

    seg_level_map #(.NCOL(NCOL)) map_i (
        .lat_bits(lat_bits), .alt(alt), .blank_n(blank_n), .seg_lvl(seg_lvl)
    );

    AST_BLANK_V0: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_n |-> (seg_lvl == '0)); // R9
endmodule

// File: tb/lcdseg_column_path_tb.sv
module lcdseg_column_path_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCOL = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic shift_stb = 1'b0, line_clk = 1'b0, width_ser = 1'b0, dir = 1'b0;
    logic chain_l_in = 1'b1, chain_r_in = 1'b1;
    logic chain_l_out, chain_r_out;
    logic [3:0] din = '0;
    logic alt = 1'b0, blank_n = 1'b1;
    logic [2*NCOL-1:0] seg_lvl;

    int n_chk = 0;
    int n_fail = 0;
    logic [NCOL-1:0] prev_row = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdseg_column_path dut_i (
        .clk(clk), .rst_n(rst_n), .shift_stb(shift_stb), .line_clk(line_clk),
        .width_ser(width_ser), .dir(dir), .chain_l_in(chain_l_in),
        .chain_r_in(chain_r_in), .chain_l_out(chain_l_out),
        .chain_r_out(chain_r_out), .din(din), .alt(alt), .blank_n(blank_n),
        .seg_lvl(seg_lvl)
    );

    function automatic logic [2*NCOL-1:0] exp_lv(logic [NCOL-1:0] r, logic a, logic b);
        logic [2*NCOL-1:0] v;
        for (int c = 0; c < NCOL; c++) begin
            if (!b)     v[2*c +: 2] = 2'b00;
            else if (!a) v[2*c +: 2] = r[c] ? 2'b00 : 2'b01;
            else        v[2*c +: 2] = r[c] ? 2'b11 : 2'b10;
        end
        return v;
    endfunction

    function automatic logic [3:0] nib_for(logic [NCOL-1:0] r, logic ser, logic d, int k);
        logic [3:0] n;
        n = 4'($urandom);
        if (ser) n[0] = d ? r[k] : r[NCOL-1-k];
        else begin
            for (int l = 0; l < 4; l++)
                n[l] = d ? r[4*k + 3 - l] : r[76 - 4*k + l];
        end
        return n;
    endfunction

    task automatic chk(string req, logic [2*NCOL-1:0] act, logic [2*NCOL-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic stb(logic [3:0] d);
        @(negedge clk); shift_stb = 1'b1; din = d;
        @(negedge clk); shift_stb = 1'b0;
    endtask

    task automatic line_pulse();
        @(negedge clk); line_clk = 1'b1;
        @(negedge clk);
        @(negedge clk); line_clk = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_en(logic active_low);
        if (dir) begin chain_l_in = active_low; chain_r_in = 1'b1; end
        else     begin chain_r_in = active_low; chain_l_in = 1'b1; end
    endtask

    function automatic logic act_out();
        return dir ? chain_r_out : chain_l_out;
    endfunction

    function automatic logic idle_out();
        return dir ? chain_l_out : chain_r_out;
    endfunction

    task automatic run_row(logic [NCOL-1:0] row, logic ser, logic d);
        int n;
        string tag;
        n = ser ? 80 : 20;
        tag = ser ? "R4" : (d ? "R3" : "R2");
        @(negedge clk); width_ser = ser; dir = d;
        line_pulse();
        // R5: strobes while the chain input is high are ignored
        set_en(1'b1);
        stb(4'hF); stb(4'h5);
        set_en(1'b0);
        for (int k = 0; k < n; k++) begin
            stb(nib_for(row, ser, d, k));
            if (k == n - 2) chk("R5/R7 chain still high before last", {159'd0, act_out()}, {159'd0, 1'b1});
        end
        chk("R7 chain low after last strobe", {159'd0, act_out()}, {159'd0, 1'b0});
        chk("R6 unused chain output high", {159'd0, idle_out()}, {159'd0, 1'b1});
        // R7: extra strobes after handoff are ignored
        stb(4'hA); stb(4'h5);
        // R8: latch unchanged until falling edge
        @(negedge clk); alt = 1'b0; blank_n = 1'b1;
        chk("R8 latch holds previous row", seg_lvl, exp_lv(prev_row, 1'b0, 1'b1));
        line_pulse();
        chk("R8 chain rearmed high", {159'd0, act_out()}, {159'd0, 1'b1});
        chk(tag, seg_lvl, exp_lv(row, 1'b0, 1'b1));
        alt = 1'b1; #1;
        chk("R9 alt high", seg_lvl, exp_lv(row, 1'b1, 1'b1));
        blank_n = 1'b0; #1;
        chk("R9 blank forces V0", seg_lvl, exp_lv(row, 1'b1, 1'b0));
        blank_n = 1'b1; alt = 1'b0;
        prev_row = row;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [NCOL-1:0] r;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 left chain high", {159'd0, chain_l_out}, {159'd0, 1'b1});
        chk("R10 right chain high", {159'd0, chain_r_out}, {159'd0, 1'b1});
        chk("R10 latch zero", seg_lvl, exp_lv('0, 1'b0, 1'b1));
        // directed corners, one per mode and direction (R1)
        run_row({NCOL{1'b1}} ^ 80'h1, 1'b0, 1'b0);
        run_row(80'h8000_0000_0000_0000_0001, 1'b0, 1'b1);
        run_row(80'h0000_0000_0000_0000_0001, 1'b1, 1'b0);
        run_row(80'h8000_0000_0000_0000_0000, 1'b1, 1'b1);
        // constrained random rows
        for (int i = 0; i < 12; i++) begin
            r = {16'($urandom), 32'($urandom), 32'($urandom)};
            run_row(r, 1'($urandom), 1'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule